// File: doc/BRIEF.md
# Parallel DAC Bus Master Sequencer

This block is the host-side master for a multi-channel parallel DAC. The DAC has a double-buffered register pair per channel and level-sensitive strobes. A simple command port takes one command at a time under a valid/ready handshake. Four commands exist: write one channel's input register, pulse the common load strobe, read one channel's input register back, or run a free-running sawtooth on one channel.

The sequencer drives the address, the data, the data-drive enable, the active-low chip select, enable and load strobes, and the read/write select. It samples the returned data bus. Each bus phase lasts a whole number of system clock cycles. That number is computed from nanosecond parameters and the clock-period parameter, rounding up, so every minimum pulse width and delay is met.

In ramp mode all strobes stay low, so the input and DAC registers are transparent and the channel output follows the data bus directly. The data climbs by a programmable step every `delay + 1` cycles and wraps modulo 256. A completion pulse marks the end of every command and carries the read data for a readback.

Top module: `dac_bus_seq`

## Requirements
- R1: During and after reset, `dac_cs_n`, `dac_en_n`, `dac_ld_n` and `dac_rw` are 1, `dac_doe` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: A write (cmd_op 0) lowers `dac_en_n`, `dac_cs_n` and `dac_rw` on the same clock edge, with the command's channel on `dac_addr` and its byte on `dac_dout`. Enable stays low for exactly ceil(EN_LOW_NS / CLK_PERIOD_NS) cycles (5 at default parameters).
- R3: After enable rises in a write, the address, the data, the low chip select and the low read/write stay unchanged for at least ceil(EN_HIGH_NS / CLK_PERIOD_NS) cycles (5 at default parameters) before chip select returns high. A channel then reads back the byte last written to it.
- R4: A load (cmd_op 1) holds `dac_ld_n` and `dac_en_n` low together for ceil(EN_LOW_NS / CLK_PERIOD_NS) cycles, with `dac_cs_n` high throughout. No channel's readback value changes as a result.
- R5: A readback (cmd_op 2) holds `dac_rw` high and `dac_cs_n` low, with enable and load high and the data drive off. `dac_din` is sampled at the edge ceil(ACCESS_NS / CLK_PERIOD_NS) cycles after chip select fell (20 at default parameters), and the sampled byte appears on `rsp_data` with the completion pulse.
- R6: After a readback, chip select returns high and stays high for at least ceil(EN_HIGH_NS / CLK_PERIOD_NS) cycles before the completion pulse.
- R7: A ramp (cmd_op 3) holds chip select, read/write, enable and load all low, with the data drive on and the channel on `dac_addr`. `dac_dout` starts at 0 and each value lasts `ramp_delay + 1` cycles. Each next value is the previous plus `ramp_step`, modulo 256, so a step of 1 runs 0 to 255 and wraps to 0.
- R8: A ramp runs until `cmd_valid` is seen at the end of a step. The value is then frozen, enable and load rise with chip select still low for ceil(EN_HIGH_NS / CLK_PERIOD_NS) cycles, and then all lines return high with a completion pulse. The pending command is not accepted before that pulse, and the channel then reads back the frozen value.
- R9: `cmd_ready` is 1 only while the sequencer is idle with all strobes and read/write high and the drive off. A command is taken on a cycle where `cmd_valid` and `cmd_ready` are both 1, and `cmd_ready` is 0 in the following cycle.
- R10: `rsp_valid` is a single-cycle pulse at the end of every command. In that cycle all strobes and read/write are high and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_op | input | 2 | 0 write, 1 load, 2 readback, 3 ramp |
| cmd_chan | input | AW (4) | Target channel |
| cmd_data | input | DW (8) | Byte for a write |
| ramp_step | input | DW (8) | Ramp increment, captured when a ramp starts |
| ramp_delay | input | DLY_W (8) | Extra cycles per ramp value, captured when a ramp starts |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | DW (8) | Byte sampled by the last readback |
| dac_addr | output | AW (4) | Channel address to the DAC |
| dac_dout | output | DW (8) | Data driven toward the DAC |
| dac_doe | output | 1 | Data drive enable (1 = master drives the data bus) |
| dac_din | input | DW (8) | Data returned by the DAC |
| dac_cs_n | output | 1 | Chip select, active low |
| dac_rw | output | 1 | Read/write select, 1 = read |
| dac_en_n | output | 1 | Enable strobe, active low |
| dac_ld_n | output | 1 | Load strobe, active low |

## Verification
The bench builds the block with its default parameters: an 8 ns clock period, 8-bit data, 4-bit addresses and an 8-bit ramp delay. These give 5-cycle enable phases and a 20-cycle access window. A bench-side model of the DAC returns corrupted data until the access window has elapsed, so sampling one cycle early shows up as wrong read data. A ramp with step 1 and no delay wraps through all 256 values within a few hundred cycles. A step of 37 with a delay of 3 exercises odd-step wraps and the hold-off of a command that arrives mid-step.

// File: rtl/dac_seq_pkg.sv
// Package: shared command and state types for the DAC bus sequencer, plus
// the nanosecond-to-cycle conversion used to size every bus phase.
// Assumes the clock period is given in whole nanoseconds and is non-zero.
package dac_seq_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_LOAD  = 2'd1,
        OP_READ  = 2'd2,
        OP_RAMP  = 2'd3
    } seq_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_WR_LO,
        S_WR_HI,
        S_LD_LO,
        S_LD_HI,
        S_RD_ACC,
        S_RD_REL,
        S_RAMP,
        S_RAMP_EXIT
    } seq_state_e;

    // Smallest whole number of cycles covering ns, never below one.
    function automatic int ns_to_cyc(input int ns, input int period);
        int c;
        c = (ns + period - 1) / period;
        if (c < 1) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/dac_phase_timer.sv
// Module: down-counter that times one bus phase.
// A start pulse loads the phase length. `last` is high in the final cycle
// of the phase, so a phase of length N lasts exactly N cycles.
// Assumes the length is at least 1.
module dac_phase_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [TW-1:0] len,
    output logic          last
);

    logic [TW-1:0] cnt;

    assign last = (cnt == '0);

    // Load on start, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (start) begin
            cnt <= len - TW'(1);
        end else if (cnt != '0) begin
            cnt <= cnt - TW'(1);
        end
    end

    // R2: between starts the counter falls by exactly one per cycle
    p_timer_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && cnt != '0) |=> (cnt == $past(cnt) - TW'(1)));

endmodule

// File: rtl/dac_ramp_gen.sv
// Module: sawtooth value generator for ramp mode.
// A start pulse captures the step and the per-value delay and clears the
// value. While `adv` is high, the value holds for delay+1 cycles and then
// adds the step, modulo 2**DW. While `adv` is low, everything is frozen.
module dac_ramp_gen #(
    parameter int DW    = 8,
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             adv,
    input  logic [DW-1:0]    step,
    input  logic [DLY_W-1:0] delay,
    output logic [DW-1:0]    value,
    output logic             tick
);

    logic [DLY_W-1:0] dcnt;
    logic [DLY_W-1:0] dly_q;
    logic [DW-1:0]    step_q;

    assign tick = (dcnt == '0);

    // Capture settings on start; step the value at each tick while advancing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value  <= '0;
            dcnt   <= '0;
            dly_q  <= '0;
            step_q <= '0;
        end else if (start) begin
            value  <= '0;
            step_q <= step;
            dly_q  <= delay;
            dcnt   <= delay;
        end else if (adv) begin
            if (tick) begin
                value <= value + step_q;
                dcnt  <= dly_q;
            end else begin
                dcnt <= dcnt - DLY_W'(1);
            end
        end
    end

    // R7: a tick while advancing moves the value by the captured step
    p_ramp_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && tick && !start) |=> (value == $past(value) + $past(step_q)));

    // R8: while not advancing, the value stays frozen
    p_ramp_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !start) |=> $stable(value));

endmodule

// File: rtl/dac_bus_seq.sv
// Module: master sequencer for a double-buffered parallel DAC bus.
// Takes one command at a time (write, load, readback, ramp) over a
// valid/ready port and plays the matching strobe sequence. Every phase
// lasts a cycle count derived from nanosecond parameters and the clock
// period. Strobes are decoded from the registered state. Assumes the
// DAC's data bus turn-around is handled by dac_doe outside this block.
module dac_bus_seq #(
    parameter int DW            = 8,
    parameter int AW            = 4,
    parameter int DLY_W         = 8,
    parameter int CLK_PERIOD_NS = 8,
    parameter int EN_LOW_NS     = 40,
    parameter int EN_HIGH_NS    = 40,
    parameter int HOLD_NS       = 10,
    parameter int ACCESS_NS     = 160
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic [1:0]       cmd_op,
    input  logic [AW-1:0]    cmd_chan,
    input  logic [DW-1:0]    cmd_data,
    input  logic [DW-1:0]    ramp_step,
    input  logic [DLY_W-1:0] ramp_delay,
    output logic             rsp_valid,
    output logic [DW-1:0]    rsp_data,
    output logic [AW-1:0]    dac_addr,
    output logic [DW-1:0]    dac_dout,
    output logic             dac_doe,
    input  logic [DW-1:0]    dac_din,
    output logic             dac_cs_n,
    output logic             dac_rw,
    output logic             dac_en_n,
    output logic             dac_ld_n
);
    import dac_seq_pkg::*;

    localparam int TW         = 16;
    localparam int EN_LO_CYC  = ns_to_cyc(EN_LOW_NS, CLK_PERIOD_NS);
    localparam int EN_HI_CYC  = ns_to_cyc(EN_HIGH_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC   = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
    localparam int ACC_CYC    = ns_to_cyc(ACCESS_NS, CLK_PERIOD_NS);
    localparam int WR_HI_CYC  = (EN_HI_CYC > HOLD_CYC) ? EN_HI_CYC : HOLD_CYC;
    localparam logic [TW-1:0] LEN_EN_LO = TW'(EN_LO_CYC);
    localparam logic [TW-1:0] LEN_EN_HI = TW'(EN_HI_CYC);
    localparam logic [TW-1:0] LEN_WR_HI = TW'(WR_HI_CYC);
    localparam logic [TW-1:0] LEN_ACC   = TW'(ACC_CYC);

    seq_state_e    state, nxt;
    seq_op_e       op;
    logic          tmr_start, tmr_last;
    logic [TW-1:0] tmr_len;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] data_q;
    logic          ramp_start, ramp_adv, ramp_tick;
    logic [DW-1:0] ramp_val;
    logic [15:0]   en_lo_run;

    assign op        = seq_op_e'(cmd_op);
    assign cmd_ready = (state == S_IDLE);
    assign dac_addr  = addr_q;

    // Next-state choice: each timed phase moves on in its last cycle.
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (cmd_valid) begin
                    unique case (op)
                        OP_WRITE: nxt = S_WR_LO;
                        OP_LOAD:  nxt = S_LD_LO;
                        OP_READ:  nxt = S_RD_ACC;
                        OP_RAMP:  nxt = S_RAMP;
                    endcase
                end
            end
            S_WR_LO:     if (tmr_last) nxt = S_WR_HI;
            S_WR_HI:     if (tmr_last) nxt = S_IDLE;
            S_LD_LO:     if (tmr_last) nxt = S_LD_HI;
            S_LD_HI:     if (tmr_last) nxt = S_IDLE;
            S_RD_ACC:    if (tmr_last) nxt = S_RD_REL;
            S_RD_REL:    if (tmr_last) nxt = S_IDLE;
            S_RAMP:      if (ramp_tick && cmd_valid) nxt = S_RAMP_EXIT;
            S_RAMP_EXIT: if (tmr_last) nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // Phase length for the state being entered; the timer restarts on entry.
    always_comb begin
        tmr_start = (nxt != state);
        unique case (nxt)
            S_WR_LO, S_LD_LO:              tmr_len = LEN_EN_LO;
            S_WR_HI:                       tmr_len = LEN_WR_HI;
            S_LD_HI, S_RD_REL, S_RAMP_EXIT: tmr_len = LEN_EN_HI;
            S_RD_ACC:                      tmr_len = LEN_ACC;
            default:                       tmr_len = TW'(1);
        endcase
    end

    // State, captured command fields, read sample and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            addr_q    <= '0;
            data_q    <= '0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            state     <= nxt;
            rsp_valid <= (state != S_IDLE) && (nxt == S_IDLE);
            if (state == S_IDLE && cmd_valid) begin
                addr_q <= cmd_chan;
                data_q <= cmd_data;
            end
            if (state == S_RD_ACC && tmr_last) begin
                rsp_data <= dac_din;
            end
        end
    end

    // Strobe decode: idle is all high with the data drive off.
    always_comb begin
        dac_cs_n = 1'b1;
        dac_rw   = 1'b1;
        dac_en_n = 1'b1;
        dac_ld_n = 1'b1;
        dac_doe  = 1'b0;
        dac_dout = data_q;
        unique case (state)
            S_WR_LO: begin
                dac_cs_n = 1'b0; dac_rw = 1'b0; dac_en_n = 1'b0; dac_doe = 1'b1;
            end
            S_WR_HI: begin
                dac_cs_n = 1'b0; dac_rw = 1'b0; dac_doe = 1'b1;
            end
            S_LD_LO: begin
                dac_en_n = 1'b0; dac_ld_n = 1'b0;
            end
            S_RD_ACC: begin
                dac_cs_n = 1'b0;
            end
            S_RAMP: begin
                dac_cs_n = 1'b0; dac_rw = 1'b0; dac_en_n = 1'b0; dac_ld_n = 1'b0;
                dac_doe  = 1'b1; dac_dout = ramp_val;
            end
            S_RAMP_EXIT: begin
                dac_cs_n = 1'b0; dac_rw = 1'b0; dac_doe = 1'b1; dac_dout = ramp_val;
            end
            default: ;
        endcase
    end

    assign ramp_start = (state == S_IDLE) && cmd_valid && (op == OP_RAMP);
    assign ramp_adv   = (state == S_RAMP) && !(ramp_tick && cmd_valid);

    dac_phase_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (tmr_start),
        .len   (tmr_len),
        .last  (tmr_last)
    );

    dac_ramp_gen #(.DW(DW), .DLY_W(DLY_W)) u_ramp (
        .clk   (clk),
        .rst_n (rst_n),
        .start (ramp_start),
        .adv   (ramp_adv),
        .step  (ramp_step),
        .delay (ramp_delay),
        .value (ramp_val),
        .tick  (ramp_tick)
    );

    // Checker state: length of the current enable-low run, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_lo_run <= '0;
        end else if (!dac_en_n) begin
            if (en_lo_run != 16'hFFFF) en_lo_run <= en_lo_run + 16'd1;
        end else begin
            en_lo_run <= '0;
        end
    end

    // R2: enable never rises before its minimum low time
    p_en_low_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dac_en_n) |-> ($past(en_lo_run) >= 16'(EN_LO_CYC - 1)));

    // R4: a load strobe with the drive off keeps chip select high
    p_load_cs_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_ld_n && !dac_doe) |-> (dac_cs_n && !dac_en_n));

    // R5: a readback keeps enable, load and the data drive off
    p_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!dac_cs_n && dac_rw) |-> (dac_en_n && dac_ld_n && !dac_doe));

    // R9: ready only with every line parked high
    p_ready_parked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (dac_cs_n && dac_en_n && dac_ld_n && dac_rw && !dac_doe));

    // R9: an accepted command drops ready in the next cycle
    p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R10: completion is a single-cycle pulse seen while idle
    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    p_rsp_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (cmd_ready && dac_cs_n && dac_en_n));

endmodule

// File: tb/tb_dac_bus_seq.sv
`timescale 1ns/1ps
module tb_dac_bus_seq;

    localparam int PER = 8;

    function automatic int cyc(input int ns);
        int c;
        c = (ns + PER - 1) / PER;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic logic [7:0] ramp_next(input logic [7:0] v, input logic [7:0] s);
        return v + s;
    endfunction

    localparam int EN_LO = cyc(40);
    localparam int EN_HI = cyc(40);
    localparam int ACC   = cyc(160);

    logic       clk, rst_n;
    logic       cmd_valid, cmd_ready;
    logic [1:0] cmd_op;
    logic [3:0] cmd_chan;
    logic [7:0] cmd_data, ramp_step, ramp_delay;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic [3:0] dac_addr;
    logic [7:0] dac_dout, dac_din;
    logic       dac_doe, dac_cs_n, dac_rw, dac_en_n, dac_ld_n;

    dac_bus_seq #(.CLK_PERIOD_NS(PER)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_data(cmd_data),
        .ramp_step(ramp_step), .ramp_delay(ramp_delay),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .dac_addr(dac_addr), .dac_dout(dac_dout), .dac_doe(dac_doe), .dac_din(dac_din),
        .dac_cs_n(dac_cs_n), .dac_rw(dac_rw), .dac_en_n(dac_en_n), .dac_ld_n(dac_ld_n)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    function automatic void check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Bus-side DAC model and protocol monitor, all at the falling edge.
    logic [7:0] bus_mem [16];
    logic [7:0] exp_mem [16];
    logic       p_en, p_cs, p_rw, p_ld;
    logic [3:0] p_addr, exp_chan;
    logic [7:0] p_dout, exp_data, r_last, cur_step;
    int         en_run, ld_run, hi_run, rel_run, rd_run, held, cur_dly;
    bit         hold_ok, in_ramp, saw_wrap, last_read;

    initial begin
        for (int i = 0; i < 16; i++) begin
            bus_mem[i] = 8'h00;
            exp_mem[i] = 8'h00;
        end
        dac_din = 8'h00;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            p_en = 1; p_cs = 1; p_rw = 1; p_ld = 1; p_addr = 0; p_dout = 0;
            en_run = 0; ld_run = 0; hi_run = 0; rel_run = 0; rd_run = 0;
            held = 0; hold_ok = 1; in_ramp = 0; last_read = 0;
        end else begin
            // Transparent input register latches on enable rise during a write.
            if (!p_en && dac_en_n && !p_cs && !p_rw) bus_mem[p_addr] = p_dout;
            // R2: write enable falls with chip select and read/write
            if (p_en && !dac_en_n && dac_ld_n)
                check(!dac_cs_n && !dac_rw && p_cs, "R2 strobes fall together",
                      {dac_cs_n, dac_rw, p_cs}, 3'b001);
            if (!p_en && dac_en_n) begin
                if (p_ld && !p_cs) begin
                    check(en_run == EN_LO, "R2 enable low width", en_run, EN_LO);
                    check(p_addr == exp_chan && p_dout == exp_data, "R2 write address/data",
                          {p_addr, p_dout}, {exp_chan, exp_data});
                end
                en_run = 0;
            end
            if (!dac_en_n) en_run++;
            // R4: load strobe with chip select high
            if (p_ld && !dac_ld_n && dac_rw)
                check(dac_cs_n && !dac_en_n, "R4 load with chip select high",
                      {dac_cs_n, dac_en_n}, 2'b10);
            if (!p_ld && dac_ld_n) begin
                if (p_rw) check(ld_run == EN_LO, "R4 load width", ld_run, EN_LO);
                ld_run = 0;
            end
            if (!dac_ld_n) ld_run++;
            // R3: hold after enable rises, before chip select is released
            if (!p_en && dac_en_n && !dac_cs_n) begin
                hi_run = 1; hold_ok = 1;
            end else if (dac_en_n && !dac_cs_n && !dac_rw && hi_run > 0) begin
                hi_run++;
                if (dac_addr != p_addr || dac_dout != p_dout) hold_ok = 0;
            end
            if (!p_cs && dac_cs_n && !p_rw) begin
                check(hi_run >= EN_HI && hold_ok, "R3 hold before release", hi_run, EN_HI);
                hi_run = 0;
            end
            // R5: readback controls, and a data source valid only after the access time
            if (p_cs && !dac_cs_n && dac_rw)
                check(dac_en_n && dac_ld_n && !dac_doe, "R5 readback controls",
                      {dac_en_n, dac_ld_n, dac_doe}, 3'b110);
            if (!dac_cs_n && dac_rw) rd_run++; else rd_run = 0;
            dac_din = (rd_run >= ACC) ? bus_mem[dac_addr] : ~bus_mem[dac_addr];
            // R10 / R6: completion with lines parked, release time after a read
            if (rsp_valid) begin
                check(dac_cs_n && dac_en_n && dac_ld_n && dac_rw && cmd_ready,
                      "R10 lines high at completion",
                      {dac_cs_n, dac_en_n, dac_ld_n, dac_rw, cmd_ready}, 5'h1f);
                if (last_read) check(rel_run >= EN_HI, "R6 release time", rel_run, EN_HI);
                last_read = 0;
            end
            if (!p_cs && dac_cs_n && p_rw) begin
                rel_run = 0; last_read = 1;
            end
            if (dac_cs_n) rel_run++;
            // R7: ramp sequence and timing
            if (!dac_cs_n && !dac_rw && !dac_en_n && !dac_ld_n) begin
                if (!in_ramp) begin
                    check(dac_dout == 8'h00, "R7 ramp starts at zero", dac_dout, 0);
                    held = 1; in_ramp = 1;
                end else if (dac_dout == r_last) begin
                    held++;
                end else begin
                    check(dac_dout == ramp_next(r_last, cur_step) && held == cur_dly + 1,
                          "R7 ramp step", {dac_dout, 8'(held)},
                          {ramp_next(r_last, cur_step), 8'(cur_dly + 1)});
                    if (dac_dout < r_last) saw_wrap = 1;
                    held = 1;
                end
                r_last = dac_dout;
            end else begin
                in_ramp = 0;
            end
            p_en = dac_en_n; p_cs = dac_cs_n; p_rw = dac_rw; p_ld = dac_ld_n;
            p_addr = dac_addr; p_dout = dac_dout;
        end
    end

    // Offer a command and hold it until taken.
    task automatic send(input logic [1:0] op, input logic [3:0] ch, input logic [7:0] d);
        @(negedge clk);
        cmd_op = op; cmd_chan = ch; cmd_data = d; cmd_valid = 1'b1;
        if (op == 2'd0) begin
            exp_chan = ch; exp_data = d;
        end
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(!cmd_ready, "R9 busy after accept", cmd_ready, 0);
    endtask

    task automatic wait_rsp(output logic [7:0] d);
        int n;
        n = 0;
        while (!rsp_valid && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(rsp_valid, "R10 completion seen", rsp_valid, 1);
        d = rsp_data;
        @(negedge clk);
        check(!rsp_valid, "R10 single-cycle pulse", rsp_valid, 0);
    endtask

    task automatic do_write(input logic [3:0] ch, input logic [7:0] d);
        logic [7:0] r;
        send(2'd0, ch, d);
        wait_rsp(r);
        exp_mem[ch] = d;
    endtask

    task automatic do_read(input logic [3:0] ch, input string req);
        logic [7:0] r;
        send(2'd2, ch, 8'h00);
        wait_rsp(r);
        check(r == exp_mem[ch], req, r, exp_mem[ch]);
    endtask

    task automatic do_load();
        logic [7:0] r;
        send(2'd1, 4'd0, 8'h00);
        wait_rsp(r);
    endtask

    task automatic start_ramp(input logic [3:0] ch, input logic [7:0] st, input logic [7:0] dl);
        ramp_step = st; ramp_delay = dl; cur_step = st; cur_dly = int'(dl);
        saw_wrap = 0;
        send(2'd3, ch, 8'h00);
    endtask

    // Offer the next command while a ramp runs; it must wait for the ramp to finish.
    task automatic stop_ramp(input logic [1:0] op, input logic [3:0] ch);
        bit early;
        int n;
        early = 0; n = 0;
        @(negedge clk);
        cmd_op = op; cmd_chan = ch; cmd_data = 8'h00; cmd_valid = 1'b1;
        while (!rsp_valid && n < 5000) begin
            if (cmd_ready) early = 1;
            @(negedge clk);
            n++;
        end
        check(rsp_valid && !early, "R8 pending command held until ramp ends",
              {rsp_valid, early}, 2'b10);
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        logic [7:0] r;
        cmd_valid = 0; cmd_op = 0; cmd_chan = 0; cmd_data = 0;
        ramp_step = 1; ramp_delay = 0; cur_step = 1; cur_dly = 0;
        exp_chan = 0; exp_data = 0; r_last = 0; saw_wrap = 0;
        rst_n = 0;
        void'($urandom(1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        check(dac_cs_n && dac_en_n && dac_ld_n && dac_rw && !dac_doe && cmd_ready && !rsp_valid,
              "R1 reset state",
              {dac_cs_n, dac_en_n, dac_ld_n, dac_rw, dac_doe, cmd_ready, rsp_valid}, 7'b1111010);
        rst_n = 1;
        @(negedge clk);
        check(dac_cs_n && dac_en_n && dac_ld_n && dac_rw && !dac_doe && cmd_ready,
              "R1 idle after reset", {dac_cs_n, dac_en_n, dac_ld_n, dac_rw, dac_doe, cmd_ready},
              6'b111101);

        // Directed writes at the channel and data extremes, read back (R2, R3, R5).
        do_write(4'd15, 8'hFF);
        do_write(4'd0, 8'h01);
        do_write(4'd7, 8'h80);
        do_read(4'd15, "R5 readback ch15");
        do_read(4'd0, "R5 readback ch0");
        // R4: load leaves input registers untouched
        do_load();
        do_read(4'd7, "R4 readback unchanged after load");
        do_read(4'd15, "R4 readback ch15 after load");

        // R7/R8: unit-step ramp, full wrap, stopped by a pending load
        start_ramp(4'd3, 8'd1, 8'd0);
        repeat (300) @(negedge clk);
        stop_ramp(2'd1, 4'd0);
        wait_rsp(r);
        check(saw_wrap, "R7 ramp wrapped past 255", saw_wrap, 1);
        exp_mem[3] = r_last;
        do_read(4'd3, "R8 frozen ramp value latched");

        // R7/R8: odd step with delay, stopped by a pending readback of the same channel
        start_ramp(4'd9, 8'd37, 8'd3);
        repeat (150) @(negedge clk);
        stop_ramp(2'd2, 4'd9);
        wait_rsp(r);
        check(saw_wrap, "R7 ramp step 37 wrapped", saw_wrap, 1);
        exp_mem[9] = r_last;
        check(r == exp_mem[9], "R8 pending readback sees frozen value", r, exp_mem[9]);

        // Random mix of writes, readbacks and loads (R2-R6, R9, R10).
        for (int i = 0; i < 80; i++) begin
            int sel;
            logic [3:0] ch;
            logic [7:0] d;
            sel = $urandom_range(0, 2);
            ch  = 4'($urandom_range(0, 15));
            d   = 8'($urandom_range(0, 255));
            if (sel == 0) do_write(ch, d);
            else if (sel == 1) do_read(ch, "R5 random readback");
            else do_load();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule